// File: doc/BRIEF.md
# Five-Decade Mode-Selectable Event Counter

A chain of decimal digit counters, units first, that counts rising transitions of a sampled count input. The whole chain runs from one system clock: the count input is sampled and a rising transition produces a one-cycle advance pulse, and each digit moves on when every digit below it sits at nine. Its main use is as a real-time or event tally whose digits feed a display. A carry-out pulse lets a further counter extend the chain.

A two-bit mode input changes how the lowest digit behaves and when it carries into the second digit. The lowest digit can act as a plain units digit. It can act as a hidden divide-by-ten front end that rounds at the midpoint. It can act as a half-unit stage that shows 0 or 5. It can also serve a test arrangement in which selected higher digits see the count pulse directly. The lowest digit's internal count runs in every mode; the mode only changes what is displayed and where the carry is taken. A per-stage advance vector shows which digits stepped on each count.

Top module: `decade_chain_counter`

## Requirements
- R1: Digits change only in the cycle after the count input is sampled high when it was sampled low on the previous clock. Holding the input high or low for any number of cycles adds no further counts.
- R2: With mode 2'b00 the lowest displayed digit equals its internal count 0..9. Digit 1 steps when digit 0 goes from 9 to 0. Every digit k above 1 steps when digit k-1 wraps from 9 to 0. Every displayed digit stays within 0..9.
- R3: With mode 2'b11 the lowest displayed digit reads 0. Digit 1 steps when the internal lowest count goes from 4 to 5.
- R4: With mode 2'b10 the lowest displayed digit reads 5 while the internal lowest count is 3..7, and reads 0 otherwise. Digit 1 steps when the internal lowest count goes from 7 to 8.
- R5: With mode 2'b01 the lowest displayed digit reads 0. Each stage whose bit is set in TEST_MASK steps on every count (the default is stages 0, 1 and 3). Every other stage steps when the stage below it wraps.
- R6: carry_out is high for exactly one cycle: the cycle in which a count has just left every internal digit at zero.
- R7: carry_out reads 1 in the cycle after rst is sampled high.
- R8: rst (synchronous, active high) clears every digit, the internal lowest count and stage_adv to zero.
- R9: stage_adv bit k is 1 in exactly the cycle in which digit k shows its newly stepped value, and 0 otherwise.
- R10: In modes where the lowest digit is hidden, its internal count keeps running. After a change of mode, the lowest displayed digit reflects the new mode one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| count_in | input | 1 | Count input, sampled; rising transitions count |
| mode | input | 2 | Front-stage mode: 00 normal, 01 test, 10 half-unit, 11 round-off |
| digits | output | NUM_DIGITS*DIGIT_W | BCD digits, digit 0 in the low nibble |
| carry_out | output | 1 | One-cycle pulse on a full wrap to zero; high after reset |
| stage_adv | output | NUM_DIGITS | Per-stage step indication for the last count |

## Verification
The bench builds the counter with NUM_DIGITS = 3 and TEST_MASK = 3'b011. In every mode this lets about a thousand counts cover the complete wrap of the chain back to zero. The carry-out pulse, every carry tap of the lowest digit and the half-unit display pattern are therefore all reached in each mode. A reference model of decimal arithmetic predicts each digit, the advance vector and the carry after every count. It also runs long held-high counts, a mid-count mode switch and reset.

// File: rtl/decade_chain_pkg.sv
package decade_chain_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_HALF   = 2'b10,
    MODE_ROUND  = 2'b11
  } chain_mode_e;
endpackage

// File: rtl/count_edge_sense.sv
// Samples the count input and flags a low-to-high change for one cycle.
module count_edge_sense (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  // Reset value 1: a level already high at reset release is not a count.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/decade_cell.sv
// One decimal stage: steps on adv_i and wraps from RADIX-1 to 0.
module decade_cell #(
  parameter int RADIX = 10,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_nxt_o
);
  localparam logic [W-1:0] TOP = W'(RADIX - 1);

  logic [W-1:0] cnt_q;

  always_comb begin
    q_nxt_o = cnt_q;
    if (adv_i) q_nxt_o = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= q_nxt_o;
  end

  assign q_o = cnt_q;
endmodule

// File: rtl/carry_router.sv
// Decides which stages step on this count, according to the front mode.
module carry_router
  import decade_chain_pkg::*;
#(
  parameter int                N          = 5,
  parameter int                W          = 4,
  parameter int                RADIX      = 10,
  parameter int                ROUND_TAP  = 4,
  parameter int                HALF_TAP   = 7,
  parameter logic [N-1:0]      TEST_MASK  = 5'b01011
) (
  input  logic           rise_i,
  input  chain_mode_e    mode_i,
  input  logic [N*W-1:0] dig_i,
  output logic [N-1:0]   adv_o
);
  localparam logic [W-1:0] TOP = W'(RADIX - 1);

  logic [W-1:0] tap;

  always_comb begin
    case (mode_i)
      MODE_ROUND: tap = W'(ROUND_TAP);
      MODE_HALF:  tap = W'(HALF_TAP);
      default:    tap = TOP;
    endcase
  end

  always_comb begin
    adv_o    = '0;
    adv_o[0] = rise_i;
    for (int k = 1; k < N; k++) begin
      if (mode_i == MODE_TEST && TEST_MASK[k])
        adv_o[k] = rise_i;
      else if (k == 1)
        adv_o[k] = rise_i && (dig_i[W-1:0] == tap);
      else
        adv_o[k] = adv_o[k-1] && (dig_i[(k-1)*W +: W] == TOP);
    end
  end
endmodule

// File: rtl/front_display.sv
// Maps the lowest stage's internal count to its shown value per mode.
module front_display
  import decade_chain_pkg::*;
#(
  parameter int W        = 4,
  parameter int HALF_LO  = 3,
  parameter int HALF_HI  = 7,
  parameter int HALF_VAL = 5
) (
  input  chain_mode_e  mode_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] shown_o
);
  always_comb begin
    case (mode_i)
      MODE_NORMAL: shown_o = raw_i;
      MODE_HALF:   shown_o = (raw_i >= W'(HALF_LO) && raw_i <= W'(HALF_HI))
                             ? W'(HALF_VAL) : '0;
      default:     shown_o = '0;
    endcase
  end
endmodule

// File: rtl/decade_chain_counter.sv
module decade_chain_counter
  import decade_chain_pkg::*;
#(
  parameter int                    NUM_DIGITS = 5,
  parameter int                    DIGIT_W    = 4,
  parameter int                    RADIX      = 10,
  parameter int                    ROUND_TAP  = 4,
  parameter int                    HALF_TAP   = 7,
  parameter int                    HALF_LO    = 3,
  parameter int                    HALF_VAL   = 5,
  parameter logic [NUM_DIGITS-1:0] TEST_MASK  = 5'b01011
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          count_in,
  input  logic [1:0]                    mode,
  output logic [NUM_DIGITS*DIGIT_W-1:0] digits,
  output logic                          carry_out,
  output logic [NUM_DIGITS-1:0]         stage_adv
);
  localparam int TOTAL_W = NUM_DIGITS * DIGIT_W;

  chain_mode_e          mode_e;
  logic                 rise;
  logic [NUM_DIGITS-1:0] adv;
  logic [TOTAL_W-1:0]   cur_flat;
  logic [TOTAL_W-1:0]   nxt_flat;
  logic [DIGIT_W-1:0]   front_shown;
  logic [DIGIT_W-1:0]   front_q;
  logic                 carry_q;
  logic [NUM_DIGITS-1:0] adv_q;
  logic                 all_zero_nxt;

  assign mode_e = chain_mode_e'(mode);

  count_edge_sense u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (count_in),
    .rise_o (rise)
  );

  carry_router #(
    .N         (NUM_DIGITS),
    .W         (DIGIT_W),
    .RADIX     (RADIX),
    .ROUND_TAP (ROUND_TAP),
    .HALF_TAP  (HALF_TAP),
    .TEST_MASK (TEST_MASK)
  ) u_router (
    .rise_i (rise),
    .mode_i (mode_e),
    .dig_i  (cur_flat),
    .adv_o  (adv)
  );

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_stage
    decade_cell #(
      .RADIX (RADIX),
      .W     (DIGIT_W)
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .adv_i   (adv[g]),
      .q_o     (cur_flat[g*DIGIT_W +: DIGIT_W]),
      .q_nxt_o (nxt_flat[g*DIGIT_W +: DIGIT_W])
    );
  end

  front_display #(
    .W        (DIGIT_W),
    .HALF_LO  (HALF_LO),
    .HALF_HI  (HALF_TAP),
    .HALF_VAL (HALF_VAL)
  ) u_front (
    .mode_i  (mode_e),
    .raw_i   (nxt_flat[DIGIT_W-1:0]),
    .shown_o (front_shown)
  );

  assign all_zero_nxt = (nxt_flat == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      front_q <= '0;
      carry_q <= 1'b1;
      adv_q   <= '0;
    end else begin
      front_q <= front_shown;
      carry_q <= rise && all_zero_nxt;
      adv_q   <= adv;
    end
  end

  assign digits    = {cur_flat[TOTAL_W-1:DIGIT_W], front_q};
  assign carry_out = carry_q;
  assign stage_adv = adv_q;
endmodule

// File: rtl/decade_chain_checker.sv
module decade_chain_checker #(
  parameter int NUM_DIGITS = 5,
  parameter int DIGIT_W    = 4,
  parameter int RADIX      = 10
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          count_in,
  input logic [1:0]                    mode,
  input logic [NUM_DIGITS*DIGIT_W-1:0] digits,
  input logic                          carry_out,
  input logic [NUM_DIGITS-1:0]         stage_adv
);
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen && !rst) begin
      assert_reset_clear_R8: assert (digits == '0 && stage_adv == '0)
        else $error("digits or stage_adv not cleared after reset");
    end
  end

  assert_reset_carry_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> carry_out);

  assert_carry_single_R6: assert property (@(posedge clk) disable iff (rst)
    carry_out |=> !carry_out);

  assert_edge_only_R1: assert property (@(posedge clk) disable iff (rst)
    stage_adv[0] |-> ($past(count_in) && !$past(count_in, 2)));

  assert_step_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    stage_adv[0] |=> !stage_adv[0]);

  assert_round_hidden_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'b11) |-> (digits[DIGIT_W-1:0] == '0));

  assert_half_values_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'b10) |->
      (digits[DIGIT_W-1:0] == '0 || digits[DIGIT_W-1:0] == DIGIT_W'(5)));

  assert_test_hidden_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'b01) |-> (digits[DIGIT_W-1:0] == '0));

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_rng
    assert_digit_range_R2: assert property (@(posedge clk) disable iff (rst)
      digits[g*DIGIT_W +: DIGIT_W] < DIGIT_W'(RADIX));
  end
endmodule

bind decade_chain_counter decade_chain_checker #(
  .NUM_DIGITS (NUM_DIGITS),
  .DIGIT_W    (DIGIT_W),
  .RADIX      (RADIX)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .count_in  (count_in),
  .mode      (mode),
  .digits    (digits),
  .carry_out (carry_out),
  .stage_adv (stage_adv)
);

// File: tb/decade_chain_counter_bench.sv
module decade_chain_counter_bench;
  localparam int ND = 3;
  localparam int DW = 4;
  localparam logic [ND-1:0] MASK = 3'b011;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              count_in = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic [ND*DW-1:0]  digits;
  logic              carry_out;
  logic [ND-1:0]     stage_adv;

  int n_tests = 0;
  int n_fail  = 0;
  int dg[ND];
  logic [ND-1:0] exp_adv;
  bit done = 1'b0;

  always #4 clk = ~clk;

  decade_chain_counter #(
    .NUM_DIGITS (ND),
    .DIGIT_W    (DW),
    .TEST_MASK  (MASK)
  ) u_decade_chain_counter (
    .clk       (clk),
    .rst       (rst),
    .count_in  (count_in),
    .mode      (mode),
    .digits    (digits),
    .carry_out (carry_out),
    .stage_adv (stage_adv)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int shown0();
    case (mode)
      2'b00:   return dg[0];
      2'b10:   return (dg[0] >= 3 && dg[0] <= 7) ? 5 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_digits();
    int v = shown0();
    for (int k = 1; k < ND; k++) v = v | (dg[k] << (k * DW));
    return v;
  endfunction

  // Reference model of one count, from the requirements.
  task automatic model_count();
    int old[ND];
    for (int k = 0; k < ND; k++) old[k] = dg[k];
    exp_adv = '0;
    exp_adv[0] = 1'b1;
    case (mode)
      2'b00: exp_adv[1] = (old[0] == 9);
      2'b11: exp_adv[1] = (old[0] == 4);
      2'b10: exp_adv[1] = (old[0] == 7);
      default: exp_adv[1] = MASK[1] ? 1'b1 : (old[0] == 9);
    endcase
    for (int k = 2; k < ND; k++)
      exp_adv[k] = (mode == 2'b01 && MASK[k]) ? 1'b1 : (exp_adv[k-1] && old[k-1] == 9);
    for (int k = 0; k < ND; k++)
      if (exp_adv[k]) dg[k] = (dg[k] + 1) % 10;
  endtask

  function automatic bit all_zero();
    for (int k = 0; k < ND; k++) if (dg[k] != 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string mode_req();
    case (mode)
      2'b00:   return "R2";
      2'b11:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    count_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 digits", int'(digits), 0);
    check("R8 stage_adv", int'(stage_adv), 0);
    check("R7 carry_out", int'(carry_out), 1);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6 carry after release", int'(carry_out), 0);
    for (int k = 0; k < ND; k++) dg[k] = 0;
  endtask

  // One count; hold = extra cycles the input stays high.
  task automatic pulse(input int hold);
    count_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    model_count();
    check(mode_req(), int'(digits), exp_digits());
    check("R9 stage_adv", int'(stage_adv), int'(exp_adv));
    check("R6 carry_out", int'(carry_out), int'(all_zero()));
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
    end
    if (hold > 0) begin
      check("R1 held high digits", int'(digits), exp_digits());
      check("R1 held high stage_adv", int'(stage_adv), 0);
    end
    count_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6 carry drops", int'(carry_out), 0);
    check("R9 stage_adv drops", int'(stage_adv), 0);
  endtask

  initial begin
    for (int k = 0; k < ND; k++) dg[k] = 0;
    repeat (2) @(posedge clk);
    for (int m = 0; m < 4; m++) begin
      logic [1:0] sel;
      sel = (m == 0) ? 2'b00 : (m == 1) ? 2'b11 : (m == 2) ? 2'b10 : 2'b01;
      @(negedge clk);
      mode = sel;
      do_reset();
      for (int p = 0; p < 1005; p++) pulse((p % 97 == 5) ? 3 : 0);
      // Idle low: R1 no counts.
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R1 idle low", int'(digits), exp_digits());
    end
    // R10: hidden front count keeps running, revealed by a mode change.
    @(negedge clk);
    mode = 2'b11;
    do_reset();
    for (int p = 0; p < 3; p++) pulse(0);
    mode = 2'b00;
    @(posedge clk);
    @(negedge clk);
    check("R10 front after mode change", int'(digits[DW-1:0]), 3);
    check("R10 model digit0", dg[0], 3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule